// File: doc/BRIEF.md
# Pause Frame Detector

This block watches the byte stream of a receive path and picks out valid flow-control pause frames. Bytes arrive on a valid/ready stream that also carries start-of-frame and end-of-frame flags. With the end-of-frame byte comes an error flag that reports a bad FCS or any other receive fault. The header is compared while the bytes go past, so no frame data is stored. Only the two bytes of pause time are kept until the verdict.

A frame is accepted when all of the following hold:
- its destination equals either the programmed station address or the reserved control multicast address;
- its type is MAC Control;
- its opcode is Pause;
- it is long enough to contain the pause time;
- it ends without an error.

On an accepted frame the block produces a one-cycle load strobe together with the new pause time. In the same cycle it raises a statistics increment pulse and steps a saturating frame counter. An interrupt pulse is also raised when the interrupt enable is set. The pause timer that consumes the load strobe is outside this block, and so is general address filtering. Detection does not depend on whether pause operation is enabled.

Back-pressure rules: the block never stalls the stream, so `rx_ready` is always high. A byte is taken only in a cycle where `rx_valid` is high. While `rx_valid` is low, the values on `rx_data`, `rx_sof`, `rx_eof` and `rx_err` have no effect.

Top module: `mac_pause_detect`

## Requirements
- R1: `rx_ready` is 1 in every cycle after reset. A cycle with `rx_valid` low takes no byte, whatever `rx_sof`, `rx_eof`, `rx_err` and `rx_data` carry.
- R2: Stream byte 0 of a frame is the first byte taken together with `rx_sof`. Bytes 0 to 5 hold the destination, and `station_addr[47:40]` is compared with byte 0 down to `station_addr[7:0]` with byte 5. If any of these bytes differs, the station address does not match.
- R3: The destination also matches when bytes 0 to 5 are 01, 80, C2, 00, 00, 01 in that order. A change in any one of those bytes rejects the frame unless the station address matches.
- R4: Bytes 12 and 13 must be 8'h88 and 8'h08. Any other value rejects the frame.
- R5: Bytes 14 and 15 must be 8'h00 and 8'h01. Any other value rejects the frame.
- R6: Byte 16 is the high byte and byte 17 the low byte of the pause time. `pause_quanta` takes that value on an accepted frame, whatever it held before, and keeps its value in every other cycle.
- R7: A frame is rejected when `rx_err` is 1 on its end-of-frame byte, or when the end-of-frame byte sits at an index below 17. A rejected frame produces no load, no interrupt and no count.
- R8: For an accepted frame, `pause_load` and `stat_inc` are 1 for exactly the one cycle that follows the clock edge that takes the end-of-frame byte.
- R9: `irq_req` is 1 in that same cycle when `irq_en` was 1 at the end-of-frame byte, and it stays 0 when `irq_en` was 0.
- R10: `pause_count` rises by one with each accepted frame and holds at 2**STAT_W-1 instead of wrapping.
- R11: A new `rx_sof` in the middle of a frame discards the bytes taken so far and starts the frame again at byte 0. Bytes taken between an end-of-frame byte and the next `rx_sof` are ignored.
- R12: During reset and after it, until a frame is accepted, `pause_load`, `stat_inc`, `irq_req`, `pause_quanta` and `pause_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Stream byte present |
| rx_ready | output | 1 | Stream accepted; tied high |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 1 | Frame error; meaningful on the end-of-frame byte |
| rx_data | input | 8 | Stream byte |
| station_addr | input | 48 | Programmed station address; bits 47:40 are byte 0 |
| irq_en | input | 1 | Interrupt enable |
| pause_load | output | 1 | One-cycle strobe: load the pause timer |
| pause_quanta | output | 16 | Pause time of the last accepted frame |
| stat_inc | output | 1 | One-cycle statistics increment |
| irq_req | output | 1 | One-cycle interrupt request |
| pause_count | output | STAT_W | Saturating count of accepted frames |

## Verification
Every result of this block is due in the cycle right after the rising edge that takes the end-of-frame byte. That covers the load strobe, the statistics pulse, the interrupt, the new pause time and the counter step, since one register stage stands between the verdict and the ports. The bench drives each byte at a falling edge. It checks all five results at the first falling edge after the edge that takes the end-of-frame byte. At the falling edge after that it checks again that the pulses have dropped. The interrupt enable is held constant across each frame, so the value seen at the end-of-frame byte is known.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Header layout, as byte indices counted from the start-of-frame byte.
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned TYPE_HI    = 12;
  localparam int unsigned TYPE_LO    = 13;
  localparam int unsigned OP_HI      = 14;
  localparam int unsigned OP_LO      = 15;
  localparam int unsigned TIME_HI    = 16;
  localparam int unsigned TIME_LO    = 17;
  localparam int unsigned HDR_BYTES  = TIME_LO + 1;

  // The position counter must be able to reach HDR_BYTES.
  localparam int unsigned POS_W = $clog2(HDR_BYTES + 1);

  localparam logic [47:0] CTRL_MCAST = 48'h0180C2000001;
  localparam logic [15:0] CTRL_TYPE  = 16'h8808;
  localparam logic [15:0] PAUSE_OP   = 16'h0001;

  typedef struct packed {
    logic dst_station;
    logic dst_mcast;
    logic type_ok;
    logic op_ok;
  } hdr_flags_t;

endpackage

// File: rtl/pfd_beat_tracker.sv
module pfd_beat_tracker
  import pfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  output logic             take,
  output logic             first,
  output logic             last,
  output logic [POS_W-1:0] cur_idx
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             in_frame_q;
  logic [POS_W-1:0] pos_q;

  // A start-of-frame byte always opens a frame, even in the middle of one.
  assign take    = beat && (sof || in_frame_q);
  assign first   = beat && sof;
  assign last    = take && eof;
  assign cur_idx = sof ? '0 : pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      pos_q      <= '0;
    end else if (take) begin
      in_frame_q <= !eof;
      pos_q      <= (cur_idx == POS_MAX) ? POS_MAX : cur_idx + 1'b1;
    end
  end

endmodule

// File: rtl/pfd_header_match.sv
module pfd_header_match
  import pfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic [POS_W-1:0] cur_idx,
  input  logic [7:0]       data,
  input  logic [47:0]      station_addr,
  output hdr_flags_t       cur_flags,
  output logic [15:0]      cur_quanta
);

  hdr_flags_t            flags_q;
  hdr_flags_t            base;
  logic [7:0]            q_hi_q;
  logic [7:0]            q_lo_q;
  logic [ADDR_BYTES-1:0] sta_hit;
  logic [ADDR_BYTES-1:0] mc_hit;

  // One byte comparator per destination byte, for each candidate address.
  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_addr_cmp
    assign sta_hit[b] = (data == station_addr[47-8*b -: 8]);
    assign mc_hit[b]  = (data == CTRL_MCAST[47-8*b -: 8]);
  end

  always_comb begin
    base      = first ? '1 : flags_q;
    cur_flags = base;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (cur_idx == POS_W'(b)) begin
        cur_flags.dst_station = base.dst_station & sta_hit[b];
        cur_flags.dst_mcast   = base.dst_mcast & mc_hit[b];
      end
    end
    if (cur_idx == POS_W'(TYPE_HI)) cur_flags.type_ok = base.type_ok & (data == CTRL_TYPE[15:8]);
    if (cur_idx == POS_W'(TYPE_LO)) cur_flags.type_ok = base.type_ok & (data == CTRL_TYPE[7:0]);
    if (cur_idx == POS_W'(OP_HI))   cur_flags.op_ok   = base.op_ok & (data == PAUSE_OP[15:8]);
    if (cur_idx == POS_W'(OP_LO))   cur_flags.op_ok   = base.op_ok & (data == PAUSE_OP[7:0]);
  end

  // The low byte of the pause time may arrive on the end-of-frame beat itself.
  assign cur_quanta = {(cur_idx == POS_W'(TIME_HI)) ? data : q_hi_q,
                       (cur_idx == POS_W'(TIME_LO)) ? data : q_lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      q_hi_q  <= '0;
      q_lo_q  <= '0;
    end else if (take) begin
      flags_q <= cur_flags;
      q_hi_q  <= cur_quanta[15:8];
      q_lo_q  <= cur_quanta[7:0];
    end
  end

endmodule

// File: rtl/pfd_sat_counter.sv
module pfd_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count <= '0;
    else if (inc && count != CNT_MAX)  count <= count + 1'b1;
  end

endmodule

// File: rtl/mac_pause_detect.sv
module mac_pause_detect
  import pfd_pkg::*;
#(
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_err,
  input  logic [7:0]        rx_data,
  input  logic [47:0]       station_addr,
  input  logic              irq_en,
  output logic              pause_load,
  output logic [15:0]       pause_quanta,
  output logic              stat_inc,
  output logic              irq_req,
  output logic [STAT_W-1:0] pause_count
);

  logic             beat;
  logic             take;
  logic             first;
  logic             last;
  logic [POS_W-1:0] cur_idx;
  hdr_flags_t       cur_flags;
  logic [15:0]      cur_quanta;
  logic             long_enough;
  logic             commit;

  // The block never stalls the stream.
  assign rx_ready = 1'b1;
  assign beat     = rx_valid & rx_ready;

  pfd_beat_tracker u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (beat),
    .sof     (rx_sof),
    .eof     (rx_eof),
    .take    (take),
    .first   (first),
    .last    (last),
    .cur_idx (cur_idx)
  );

  pfd_header_match u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .first        (first),
    .cur_idx      (cur_idx),
    .data         (rx_data),
    .station_addr (station_addr),
    .cur_flags    (cur_flags),
    .cur_quanta   (cur_quanta)
  );

  assign long_enough = (cur_idx >= POS_W'(TIME_LO));
  assign commit = last && !rx_err && long_enough
                  && (cur_flags.dst_station || cur_flags.dst_mcast)
                  && cur_flags.type_ok && cur_flags.op_ok;

  pfd_sat_counter #(.W(STAT_W)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (commit),
    .count (pause_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_load   <= 1'b0;
      stat_inc     <= 1'b0;
      irq_req      <= 1'b0;
      pause_quanta <= '0;
    end else begin
      pause_load <= commit;
      stat_inc   <= commit;
      irq_req    <= commit && irq_en;
      if (commit) pause_quanta <= cur_quanta;
    end
  end

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
  parameter int unsigned STAT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rx_eof,
  input logic              rx_err,
  input logic              irq_en,
  input logic              pause_load,
  input logic [15:0]       pause_quanta,
  input logic              stat_inc,
  input logic              irq_req,
  input logic [STAT_W-1:0] pause_count
);

  localparam logic [STAT_W-1:0] CNT_MAX = '1;

  assert_ready_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pause_load |=> !pause_load);

  assert_load_after_good_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pause_load |-> $past(rx_valid && rx_eof && !rx_err));

  assert_no_load_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_valid && rx_eof && rx_err) |-> !pause_load);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pause_load && $past(irq_en)));

  assert_quanta_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_load |-> $stable(pause_quanta));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_count != $past(pause_count)) |->
      (stat_inc && pause_count == STAT_W'($past(pause_count) + 1'b1)));

  assert_count_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pause_count) == CNT_MAX) |-> (pause_count == CNT_MAX));

endmodule

bind mac_pause_detect pfd_checker #(.STAT_W(STAT_W)) u_pfd_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .rx_eof       (rx_eof),
  .rx_err       (rx_err),
  .irq_en       (irq_en),
  .pause_load   (pause_load),
  .pause_quanta (pause_quanta),
  .stat_inc     (stat_inc),
  .irq_req      (irq_req),
  .pause_count  (pause_count)
);

// File: tb/mac_pause_detect_bench.sv
module mac_pause_detect_bench;

  localparam int          CLK_PERIOD = 10;
  localparam int          STAT_W     = 3;
  localparam int          CNT_TOP    = (1 << STAT_W) - 1;
  localparam logic [47:0] STA        = 48'h021122334455;
  localparam logic [47:0] MCAST      = 48'h0180C2000001;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rx_valid = 1'b0;
  logic              rx_ready;
  logic              rx_sof = 1'b0;
  logic              rx_eof = 1'b0;
  logic              rx_err = 1'b0;
  logic [7:0]        rx_data = 8'h00;
  logic              irq_en = 1'b0;
  logic              pause_load;
  logic [15:0]       pause_quanta;
  logic              stat_inc;
  logic              irq_req;
  logic [STAT_W-1:0] pause_count;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  logic [15:0] exp_q = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_pause_detect #(.STAT_W(STAT_W)) u_mac_pause_detect (
    .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_ready (rx_ready),
    .rx_sof (rx_sof), .rx_eof (rx_eof), .rx_err (rx_err), .rx_data (rx_data),
    .station_addr (STA), .irq_en (irq_en), .pause_load (pause_load),
    .pause_quanta (pause_quanta), .stat_inc (stat_inc), .irq_req (irq_req),
    .pause_count (pause_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] fbyte(input int i, input logic [47:0] dst,
                                       input logic [15:0] typ, input logic [15:0] op,
                                       input logic [15:0] qt);
    if (i < 6)        return dst[47-8*i -: 8];
    else if (i < 12)  return 8'(8'h30 + i);
    else if (i == 12) return typ[15:8];
    else if (i == 13) return typ[7:0];
    else if (i == 14) return op[15:8];
    else if (i == 15) return op[7:0];
    else if (i == 16) return qt[15:8];
    else if (i == 17) return qt[7:0];
    else              return 8'(i * 7);
  endfunction

  // Drive len bytes; idle cycles carry misleading flags that must be ignored (R1).
  task automatic drive_bytes(input logic [47:0] dst, input logic [15:0] typ,
                             input logic [15:0] op, input logic [15:0] qt, input int len,
                             input bit with_sof, input bit with_eof, input bit err,
                             input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b1; rx_eof = 1'b1; rx_err = 1'b0; rx_data = 8'hA5;
      end
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = with_sof && (i == 0);
      rx_eof   = with_eof && (i == len - 1);
      rx_err   = (i == len - 1) ? err : 1'b1;
      rx_data  = fbyte(i, dst, typ, op, qt);
    end
  endtask

  // Called right after the end-of-frame byte has been driven.
  task automatic expect_result(input bit ok, input logic [15:0] qt, input string tag);
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    if (ok) begin
      exp_q = qt;
      if (exp_cnt < CNT_TOP) exp_cnt++;
    end
    check({tag, " R8 load"}, 32'(pause_load), 32'(ok));
    check({tag, " R8 stat_inc"}, 32'(stat_inc), 32'(ok));
    check({tag, " R9 irq"}, 32'(irq_req), 32'(ok && irq_en));
    check({tag, " R6 quanta"}, 32'(pause_quanta), 32'(exp_q));
    check({tag, " R10 count"}, 32'(pause_count), 32'(exp_cnt));
    @(negedge clk);
    check({tag, " R8 pulse ends"}, 32'(pause_load), 32'd0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [47:0] dsts [9];
    logic [15:0] typs [3];
    logic [15:0] ops  [3];
    int          lens [3];
    dsts[0] = STA; dsts[1] = MCAST; dsts[8] = MCAST ^ 48'h1;
    for (int b = 0; b < 6; b++) dsts[2+b] = STA ^ (48'h10 << (8*(5-b)));
    typs[0] = 16'h8808; typs[1] = 16'h8809; typs[2] = 16'h0808;
    ops[0]  = 16'h0001; ops[1]  = 16'h0000; ops[2]  = 16'h0101;
    lens[0] = 17; lens[1] = 18; lens[2] = 25;

    // R12: reset state
    repeat (3) @(negedge clk);
    check("R12 reset load", 32'(pause_load), 0);
    check("R12 reset quanta", 32'(pause_quanta), 0);
    check("R12 reset count", 32'(pause_count), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 idle irq", 32'(irq_req), 0);
    check("R12 idle stat", 32'(stat_inc), 0);
    check("R1 ready", 32'(rx_ready), 1);

    // R2 R3 R10: accepted frames walk the counter upward
    for (int k = 0; k < 6; k++) begin
      irq_en = k[0];
      drive_bytes((k % 2) ? MCAST : STA, 16'h8808, 16'h0001, 16'(16'hC000 + k * 97),
                  18 + k, 1'b1, 1'b1, 1'b0, k[1]);
      expect_result(1'b1, 16'(16'hC000 + k * 97), "R2 R3 warmup");
    end

    // R2 to R7, R9, R10: sweep of header and status variants
    for (int d = 0; d < 9; d++)
      for (int t = 0; t < 3; t++)
        for (int o = 0; o < 3; o++)
          for (int e = 0; e < 2; e++)
            for (int l = 0; l < 3; l++) begin
              int  k;
              bit  ok;
              logic [15:0] qt;
              k  = (((d * 3 + t) * 3 + o) * 2 + e) * 3 + l;
              qt = 16'(k * 257 + 3);
              ok = (dsts[d] == STA || dsts[d] == MCAST) && t == 0 && o == 0 &&
                   e == 0 && lens[l] >= 18;
              irq_en = (k % 3) != 0;
              drive_bytes(dsts[d], typs[t], ops[o], qt, lens[l], 1'b1, 1'b1, e[0], (k % 4) == 1);
              expect_result(ok, qt, "R2 R3 R4 R5 R7 sweep");
            end

    // R11: bytes without a start-of-frame are ignored
    irq_en = 1'b1;
    drive_bytes(MCAST, 16'h8808, 16'h0001, 16'h7777, 20, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_result(1'b0, 16'h7777, "R11 stray");
    // R11: restart discards a bad prefix
    drive_bytes(48'hFFFFFFFFFFFF, 16'h0, 16'h0, 16'h0, 9, 1'b1, 1'b0, 1'b0, 1'b0);
    drive_bytes(STA, 16'h8808, 16'h0001, 16'h4321, 18, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_result(1'b1, 16'h4321, "R11 restart good");
    // R11: restart discards a good prefix
    drive_bytes(STA, 16'h8808, 16'h0001, 16'h1111, 16, 1'b1, 1'b0, 1'b0, 1'b0);
    drive_bytes(STA, 16'h8808, 16'h0002, 16'h2222, 18, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_result(1'b0, 16'h2222, "R11 restart bad");
    check("R1 ready end", 32'(rx_ready), 1);

    finish_run();
  end

endmodule